// File: doc/BRIEF.md
# Auto-Increment Microcode RAM Loader

This block is the host-side load path into a coprocessor's 32-bit instruction RAM. The host never addresses the RAM directly. It first writes a pointer register with a starting word offset and two flags. It then streams microcode through a single data register. Each data write lands one word at the current pointer. When the auto-increment flag is set, the pointer then moves on by one word, so a whole image can be pushed with one pointer write followed by back-to-back data writes.

A 16-bit control register holds a split/shared flag. In shared mode the whole RAM is one region and the pointer wraps at the top of the array. In split mode the RAM is divided into one equal region per processor. The pointer then stays inside the region it started in and wraps back to that region's first word. Every wrap sets a sticky flag, so software can tell that an image ran past the end of its space.

A separate registered read port lets a bench inspect any RAM word. Reset puts the pointer, both flags and the split bit back to zero and leaves the RAM contents in place. Any loaded image is treated as discarded and must be loaded again.

Top module: `iram_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer, auto-increment flag, base flag, split bit and wrap flag all clear. After reset, reads of the pointer register (select 0) and the control register (select 2) return 0.
- R2: A write to select 0 loads the pointer from data bits [AW-1:0], the auto-increment flag from bit 31 and the base flag from bit 19. Reading select 0 returns the auto-increment flag in bit 31, the base flag in bit 19 and the pointer in bits [AW-1:0], with all other bits zero.
- R3: A write to select 1 stores the 32-bit data word at the current pointer. Presenting that word's address on `rb_addr` returns the word on `rb_data` one clock later.
- R4: With auto-increment set, and no region end reached, each select-1 write advances the pointer by one.
- R5: With auto-increment clear, select-1 writes leave the pointer unchanged, so each new word overwrites the same location.
- R6: In shared mode (split bit 0), a select-1 write at pointer DEPTH-1 with auto-increment set moves the pointer to 0 and sets the wrap flag. The wrap flag reads back in bit 0 of select 2.
- R7: In split mode, the RAM forms NPROC equal regions selected by the upper pointer bits. A select-1 write at a region's last word, with auto-increment set, moves the pointer to that region's first word and sets the wrap flag.
- R8: The wrap flag stays set until the next write to select 0, which clears it.
- R9: In the control register, only bit 11 (the split bit) is writable. Its other bits read 0, except bit 0, which is the wrap flag.
- R10: `host_rdata` is registered. It shows the register chosen by `host_sel` at the previous clock edge, with the values held before any write at that edge. Reads of select 1 and select 3 return 0.
- R11: A write to select 3 has no effect on any register or on the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 pointer, 1 data, 2 control, 3 unused |
| host_we | input | 1 | Write strobe for the selected register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data of the selected register |
| rb_addr | input | AW | Read-back word address |
| rb_data | output | 32 | Registered read-back word |

## Verification
The assertions assume that `host_sel` and `host_we` are known at every clock edge once reset is released. They also assume that only one register is written per cycle, which a single select field guarantees. The stepping checks further assume that DEPTH and NPROC are powers of two. The bench drives a single host transaction at a time on the falling edge and leaves idle cycles between writes. It keeps `rb_addr` stable while reading. It compares the read-back data only at addresses that have already been written, because the RAM has no reset value.

// File: rtl/iram_loader_pkg.sv
package iram_loader_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_WORD = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  localparam int AINC_BIT  = 31;
  localparam int BASE_BIT  = 19;
  localparam int SPLIT_BIT = 11;
  localparam int WRAP_BIT  = 0;
endpackage

// File: rtl/iram_ptr_unit.sv
module iram_ptr_unit #(
  parameter int AW = 12,
  parameter int NPROC = 2,
  localparam int RB = (NPROC > 1) ? $clog2(NPROC) : 0,
  localparam int LW = AW - RB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_ptr,
  input  logic          load_ainc,
  input  logic          load_base,
  input  logic          step,
  input  logic          split,
  output logic [AW-1:0] ptr,
  output logic          ainc,
  output logic          base,
  output logic          wrap
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << LW) - 64'd1);

  logic          at_end;
  logic [AW-1:0] nxt;

  always_comb begin
    if (split) at_end = ((ptr & LOW_MASK) == LOW_MASK);
    else       at_end = &ptr;
    if (!at_end)    nxt = ptr + AW'(1);
    else if (split) nxt = ptr & ~LOW_MASK;
    else            nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      ainc <= 1'b0;
      base <= 1'b0;
      wrap <= 1'b0;
    end else if (load) begin
      ptr  <= load_ptr;
      ainc <= load_ainc;
      base <= load_base;
      wrap <= 1'b0;
    end else if (step && ainc) begin
      ptr <= nxt;
      if (at_end) wrap <= 1'b1;
    end
  end
endmodule

// File: rtl/iram_ctrl_reg.sv
module iram_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic split_in,
  output logic split
);
  always_ff @(posedge clk) begin
    if (rst)     split <= 1'b0;
    else if (wr) split <= split_in;
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int DEPTH = 4096,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/iram_loader.sv
module iram_loader
  import iram_loader_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int NPROC = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    host_sel,
  input  logic          host_we,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [AW-1:0] rb_addr,
  output logic [31:0]   rb_data
);
  host_sel_e     sel;
  logic          wr_ptr, wr_word, wr_ctrl;
  logic [AW-1:0] ptr;
  logic          ainc, base, wrap, split;
  logic [31:0]   rd_next;

  assign sel     = host_sel_e'(host_sel);
  assign wr_ptr  = host_we && (sel == SEL_PTR);
  assign wr_word = host_we && (sel == SEL_WORD);
  assign wr_ctrl = host_we && (sel == SEL_CTRL);

  iram_ptr_unit #(.AW(AW), .NPROC(NPROC)) u_ptr (
    .clk(clk), .rst(rst),
    .load(wr_ptr), .load_ptr(host_wdata[AW-1:0]),
    .load_ainc(host_wdata[AINC_BIT]), .load_base(host_wdata[BASE_BIT]),
    .step(wr_word), .split(split),
    .ptr(ptr), .ainc(ainc), .base(base), .wrap(wrap)
  );

  iram_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl),
    .split_in(host_wdata[SPLIT_BIT]), .split(split)
  );

  iram_store #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk(clk), .we(wr_word), .waddr(ptr), .wdata(host_wdata),
    .raddr(rb_addr), .rdata(rb_data)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_PTR: begin
        rd_next[AINC_BIT] = ainc;
        rd_next[BASE_BIT] = base;
        rd_next[AW-1:0]   = ptr;
      end
      SEL_CTRL: begin
        rd_next[SPLIT_BIT] = split;
        rd_next[WRAP_BIT]  = wrap;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_next;
  end
endmodule

// File: rtl/iram_loader_chk.sv
module iram_loader_chk #(
  parameter int AW = 12,
  parameter int NPROC = 2,
  localparam int RB = (NPROC > 1) ? $clog2(NPROC) : 0,
  localparam int LW = AW - RB
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    host_sel,
  input logic          host_we,
  input logic [AW-1:0] ld_ptr,
  input logic          ld_ainc,
  input logic [AW-1:0] ptr,
  input logic          ainc,
  input logic          split,
  input logic          wrap
);
  localparam logic [AW-1:0] LOW = AW'((64'd1 << LW) - 64'd1);

  logic ptr_wr, word_wr;
  assign ptr_wr  = host_we && (host_sel == 2'd0);
  assign word_wr = host_we && (host_sel == 2'd1);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ptr == '0 && !ainc && !split && !wrap));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (ptr == $past(ld_ptr) && ainc == $past(ld_ainc)));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (word_wr && ainc && ((ptr & LOW) != LOW)) |=> (ptr == $past(ptr) + AW'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (word_wr && !ainc) |=> $stable(ptr));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (word_wr && ainc && !split && (&ptr)) |=> (ptr == '0 && wrap));

  p_region_r7: assert property (@(posedge clk) disable iff (rst)
    (word_wr && ainc && split) |=> ((ptr & ~LOW) == ($past(ptr) & ~LOW)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wrap && !ptr_wr) |=> wrap);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> !wrap);
endmodule

bind iram_loader iram_loader_chk #(.AW(AW), .NPROC(NPROC)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
  .ld_ptr(host_wdata[AW-1:0]), .ld_ainc(host_wdata[31]),
  .ptr(ptr), .ainc(ainc), .split(split), .wrap(wrap)
);

// File: tb/iram_loader_tb.sv
module iram_loader_tb;
  localparam int DEPTH = 4096;
  localparam int AW = 12;
  localparam int HALF = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    host_sel = 2'd0;
  logic          host_we = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic [AW-1:0] rb_addr = '0;
  logic [31:0]   rb_data;

  int n_run = 0;
  int n_fail = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  iram_loader #(.DEPTH(DEPTH), .NPROC(2)) u_dut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rb_addr(rb_addr), .rb_data(rb_data)
  );

  // behavioural reference model
  int unsigned m_ptr = 0;
  bit m_ainc = 0, m_base = 0, m_split = 0, m_wrap = 0;
  logic [31:0] m_mem [DEPTH];
  bit m_val [DEPTH];
  logic [31:0] e_host = '0, e_rb = '0;
  bit e_rb_ok = 0, e_live = 0;

  function automatic logic [31:0] model_read(input logic [1:0] s);
    logic [31:0] v = '0;
    if (s == 2'd0) v = (32'(m_ainc) << 31) | (32'(m_base) << 19) | 32'(m_ptr);
    else if (s == 2'd2) v = (32'(m_split) << 11) | 32'(m_wrap);
    return v;
  endfunction

  always @(posedge clk) begin
    e_host  = rst ? 32'h0 : model_read(host_sel);
    e_rb_ok = m_val[rb_addr];
    e_rb    = m_mem[rb_addr];
    e_live  = 1;
    if (rst) begin
      m_ptr = 0; m_ainc = 0; m_base = 0; m_split = 0; m_wrap = 0;
    end else if (host_we) begin
      if (host_sel == 2'd0) begin
        m_ptr = host_wdata % DEPTH;
        m_ainc = host_wdata[31]; m_base = host_wdata[19]; m_wrap = 0;
      end else if (host_sel == 2'd1) begin
        m_mem[m_ptr] = host_wdata; m_val[m_ptr] = 1;
        if (m_ainc) begin
          if (m_split) begin
            if (m_ptr % HALF == HALF - 1) begin m_ptr = m_ptr - (HALF - 1); m_wrap = 1; end
            else m_ptr = m_ptr + 1;
          end else begin
            if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_wrap = 1; end
            else m_ptr = m_ptr + 1;
          end
        end
      end else if (host_sel == 2'd2) begin
        m_split = host_wdata[11];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (e_live) begin
      chk({phase, "/R10"}, "host_rdata vs model", host_rdata, e_host);
      if (e_rb_ok) chk({phase, "/R3"}, "rb_data vs model", rb_data, e_rb);
    end
  end

  task automatic hwrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); host_sel = s; host_we = 1'b1; host_wdata = d;
    @(negedge clk); host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic hread(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); host_sel = s; host_we = 1'b0;
    @(negedge clk); v = host_rdata;
  endtask

  task automatic rbread(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); rb_addr = a;
    @(negedge clk); v = rb_data;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    phase = "R1";
    hread(2'd0, v); chk("R1", "pointer after reset", v, 32'h0);
    hread(2'd2, v); chk("R1", "control after reset", v, 32'h0);

    phase = "R2";
    hwrite(2'd0, 32'h8008_0010);
    hread(2'd0, v); chk("R2", "pointer fields", v, 32'h8008_0010);
    hwrite(2'd0, 32'hFFFF_FFFF);
    hread(2'd0, v); chk("R2", "pointer masked", v, 32'h8008_0FFF);

    phase = "R4";
    hwrite(2'd0, 32'h8000_0010);
    hwrite(2'd1, 32'hA1A1_0001);
    hwrite(2'd1, 32'hB2B2_0002);
    hwrite(2'd1, 32'hC3C3_0003);
    hread(2'd0, v); chk("R4", "pointer after 3 words", v, 32'h8000_0013);
    phase = "R3";
    rbread(12'h010, v); chk("R3", "word 0x010", v, 32'hA1A1_0001);
    rbread(12'h011, v); chk("R3", "word 0x011", v, 32'hB2B2_0002);
    rbread(12'h012, v); chk("R3", "word 0x012", v, 32'hC3C3_0003);

    phase = "R5";
    hwrite(2'd0, 32'h0000_0020);
    hwrite(2'd1, 32'hD4D4_0004);
    hwrite(2'd1, 32'hE5E5_0005);
    hread(2'd0, v); chk("R5", "pointer held", v, 32'h0000_0020);
    rbread(12'h020, v); chk("R5", "overwritten word", v, 32'hE5E5_0005);

    phase = "R6";
    hwrite(2'd0, 32'h8000_0FFE);
    hwrite(2'd1, 32'h1111_0001);
    hwrite(2'd1, 32'h2222_0002);
    hwrite(2'd1, 32'h3333_0003);
    hread(2'd0, v); chk("R6", "pointer after wrap", v, 32'h8000_0001);
    hread(2'd2, v); chk("R6", "wrap flag", v, 32'h0000_0001);
    rbread(12'hFFF, v); chk("R6", "last word", v, 32'h2222_0002);
    rbread(12'h000, v); chk("R6", "word after wrap", v, 32'h3333_0003);

    phase = "R9";
    hwrite(2'd2, 32'hFFFF_FFFF);
    hread(2'd2, v); chk("R9", "control masked", v, 32'h0000_0801);

    phase = "R8";
    hwrite(2'd1, 32'h4444_0004);
    hread(2'd2, v); chk("R8", "wrap sticky", v, 32'h0000_0801);
    hwrite(2'd0, 32'h8000_0100);
    hread(2'd2, v); chk("R8", "wrap cleared", v, 32'h0000_0800);

    phase = "R7";
    hwrite(2'd0, 32'h8000_0FFF);
    hwrite(2'd1, 32'h5555_0005);
    hwrite(2'd1, 32'h6666_0006);
    hread(2'd0, v); chk("R7", "upper region wrap", v, 32'h8000_0801);
    rbread(12'hFFF, v); chk("R7", "word 0xFFF", v, 32'h5555_0005);
    rbread(12'h800, v); chk("R7", "word 0x800", v, 32'h6666_0006);
    hwrite(2'd0, 32'h8000_07FF);
    hwrite(2'd1, 32'h7777_0007);
    hread(2'd0, v); chk("R7", "lower region wrap", v, 32'h8000_0000);
    hread(2'd2, v); chk("R7", "wrap flag split", v, 32'h0000_0801);

    phase = "R11";
    hwrite(2'd3, 32'hFFFF_FFFF);
    hread(2'd0, v); chk("R11", "pointer untouched", v, 32'h8000_0000);
    hread(2'd2, v); chk("R11", "control untouched", v, 32'h0000_0801);
    rbread(12'h000, v); chk("R11", "RAM untouched", v, 32'h3333_0003);
    phase = "R10";
    hread(2'd1, v); chk("R10", "data select reads zero", v, 32'h0);
    hread(2'd3, v); chk("R10", "unused select reads zero", v, 32'h0);

    phase = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    hread(2'd2, v); chk("R1", "control after second reset", v, 32'h0);
    hread(2'd0, v); chk("R1", "pointer after second reset", v, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule